// File: doc/BRIEF.md
# Split Quotient Digit Selector by Threshold Comparison

This combinational block picks one quotient digit per division iteration. It splits the digit into a high part and a low part. The residual estimate arrives in carry-save form as a truncated sum word and a truncated carry word. A 3-bit index names the divisor-estimate interval, and a flag chooses between radix-16 and radix-10 operation.

The high part comes from comparing the estimate with a row of stored positive constants and with their negatives. Each comparison is a 3:2 carry-save reduction of the sum word, the carry word and the negated constant, followed by a sign test. While the high part is being chosen, the block also works out every possible low part. For each candidate high digit c, it reduces the estimate minus c times the truncated k·d estimate and tests that value against the low constants. The low part is then picked by the high part that was actually chosen.

Top module: `split_qdigit_select`

## Requirements
- R1: The interval index `div_idx` (0 to 7) selects one row of constants (hi2, hi1, lo2, lo1). The rows are: 0: 50,16,13,4; 1: 56,16,14,4; 2: 66,20,16,5; 3: 68,20,17,5; 4: 72,24,18,6; 5: 80,24,20,6; 6: 88,28,22,7; 7: 88,28,22,7. Radix-10 operation uses the hi1, lo2 and lo1 entries of the same row.
- R2: With `radix16`=1, the high digit is the number of thresholds in {hi2, hi1, −hi1, −hi2} that the estimate y is greater than or equal to, minus 2. This gives a value in −2..2.
- R3: With `radix16`=0, the high digit is the number of thresholds in {hi1, −hi1} that y is greater than or equal to, minus 1. This gives a value in −1..1.
- R4: The low digit is found from v = y − qh·kd, where qh is the chosen high digit. It is the number of thresholds in {lo2, lo1, −lo1, −lo2} that v is greater than or equal to, minus 2. This rule is the same in both radices.
- R5: Both digits are output as 3-bit sign-magnitude values. Bit 2 is the sign (1 = negative) and bits 1:0 are the magnitude. Zero is always 000, never 100.
- R6: An estimate exactly equal to a threshold falls into the higher digit region.
- R7: y is the exact sum of `est_sum` and `est_carry`, each read as two's complement. `kd_est` is unsigned. Full-range operands never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| est_sum | input | EW (10) | Truncated residual estimate, sum word, two's complement |
| est_carry | input | EW (10) | Truncated residual estimate, carry word, two's complement |
| div_idx | input | 3 | Divisor-estimate interval index |
| kd_est | input | KW (9) | Truncated k·d estimate, unsigned |
| radix16 | input | 1 | 1 selects radix-16 digit sets, 0 selects radix-10 |
| q_hi | output | 3 | High digit, sign-magnitude |
| q_lo | output | 3 | Low digit, sign-magnitude |

## Verification
The high-digit comparison and the speculative low-digit selection settle in the same evaluation. A wrong mux choice therefore looks correct whenever the candidate low digits happen to agree. Directed vectors place the estimate exactly on high thresholds and choose kd values that drive the shifted estimate onto low thresholds, so that neighbouring candidates differ. Every vector, and a random sweep over all eight intervals and both radices, is judged against an integer threshold model of both digits.

// File: rtl/split_qdigit_select.sv
module split_qdigit_select #(
  parameter int EW = 10,
  parameter int KW = 9
) (
  input  logic [EW-1:0] est_sum,
  input  logic [EW-1:0] est_carry,
  input  logic [2:0]    div_idx,
  input  logic [KW-1:0] kd_est,
  input  logic          radix16,
  output logic [2:0]    q_hi,
  output logic [2:0]    q_lo
);
  localparam int IW = EW + 4;
  localparam int ND = 5;

  logic [IW-1:0] ys, yc, kd1, kd2;
  logic [IW-1:0] h2, h1, l2, l1;

  assign ys  = {{(IW-EW){est_sum[EW-1]}}, est_sum};
  assign yc  = {{(IW-EW){est_carry[EW-1]}}, est_carry};
  assign kd1 = {{(IW-KW){1'b0}}, kd_est};
  assign kd2 = kd1 << 1;

  always_comb begin
    case (div_idx)
      3'd0:    {h2, h1, l2, l1} = {IW'(50), IW'(16), IW'(13), IW'(4)};
      3'd1:    {h2, h1, l2, l1} = {IW'(56), IW'(16), IW'(14), IW'(4)};
      3'd2:    {h2, h1, l2, l1} = {IW'(66), IW'(20), IW'(16), IW'(5)};
      3'd3:    {h2, h1, l2, l1} = {IW'(68), IW'(20), IW'(17), IW'(5)};
      3'd4:    {h2, h1, l2, l1} = {IW'(72), IW'(24), IW'(18), IW'(6)};
      3'd5:    {h2, h1, l2, l1} = {IW'(80), IW'(24), IW'(20), IW'(6)};
      default: {h2, h1, l2, l1} = {IW'(88), IW'(28), IW'(22), IW'(7)};
    endcase
  end

  // 3:2 reduction of (a, b, -m) then sign test: 1 when a + b >= m
  function automatic logic at_least(input logic [IW-1:0] a, input logic [IW-1:0] b,
                                    input logic [IW-1:0] m);
    logic [IW-1:0] nm, s, c, t;
    nm = ~m;
    s  = a ^ b ^ nm;
    c  = ((a & b) | (a & nm) | (b & nm)) << 1;
    t  = s + c + IW'(1);
    return ~t[IW-1];
  endfunction

  function automatic logic [2:0] count4(input logic a, input logic b,
                                        input logic c, input logic d);
    return {2'b00, a} + {2'b00, b} + {2'b00, c} + {2'b00, d};
  endfunction

  // digit index 0..4 stands for digit -2..2
  function automatic logic [2:0] to_sm(input logic [2:0] idx);
    return (idx >= 3'd2) ? (idx - 3'd2) : {1'b1, 2'(3'd2 - idx)};
  endfunction

  logic [2:0] hi_cnt16, hi_idx;
  logic [1:0] hi_cnt10;
  logic [2:0] lo_cnt [ND];

  assign hi_cnt16 = count4(at_least(ys, yc, h2), at_least(ys, yc, h1),
                           at_least(ys, yc, -h1), at_least(ys, yc, -h2));
  assign hi_cnt10 = {1'b0, at_least(ys, yc, h1)} + {1'b0, at_least(ys, yc, -h1)};
  assign hi_idx   = radix16 ? hi_cnt16 : ({1'b0, hi_cnt10} + 3'd1);

  for (genvar c = 0; c < ND; c++) begin : g_spec
    logic [IW-1:0] term, vs, vc;
    if (c == 0)      begin : g_m2 assign term = kd2;  end
    else if (c == 1) begin : g_m1 assign term = kd1;  end
    else if (c == 2) begin : g_z  assign term = '0;   end
    else if (c == 3) begin : g_p1 assign term = -kd1; end
    else             begin : g_p2 assign term = -kd2; end
    assign vs = ys ^ yc ^ term;
    assign vc = ((ys & yc) | (ys & term) | (yc & term)) << 1;
    assign lo_cnt[c] = count4(at_least(vs, vc, l2), at_least(vs, vc, l1),
                              at_least(vs, vc, -l1), at_least(vs, vc, -l2));
  end

  assign q_hi = to_sm(hi_idx);
  assign q_lo = to_sm(lo_cnt[hi_idx]);

  logic signed [IW-1:0] y_chk;
  assign y_chk = $signed(ys) + $signed(yc);

  always_comb begin
    if (!$isunknown({est_sum, est_carry, div_idx, kd_est, radix16})) begin
      a_r5_no_neg_zero: assert (q_hi != 3'b100 && q_lo != 3'b100)
        else $error("negative zero digit");
      a_r3_r10_hi_range: assert (radix16 || q_hi[1] == 1'b0)
        else $error("radix-10 high digit out of range");
      a_r4_mag_range: assert (q_hi[1:0] != 2'b11 && q_lo[1:0] != 2'b11)
        else $error("digit magnitude above 2");
      a_r2_hi_sign: assert ((q_hi[1:0] == 2'b00) ||
                            (q_hi[2] ? (y_chk < 0) : (y_chk > 0)))
        else $error("high digit sign disagrees with estimate");
    end
  end
endmodule

// File: tb/tb_split_qdigit_select.sv
`timescale 1ns/1ps
module tb_split_qdigit_select;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [9:0] est_sum, est_carry;
  logic [2:0] div_idx;
  logic [8:0] kd_est;
  logic       radix16;
  logic [2:0] q_hi, q_lo;

  split_qdigit_select dut (.est_sum(est_sum), .est_carry(est_carry), .div_idx(div_idx),
                           .kd_est(kd_est), .radix16(radix16), .q_hi(q_hi), .q_lo(q_lo));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // ys, yc, idx, kd, radix16, expected hi, expected lo
  localparam int NV = 14;
  localparam int VEC [NV][7] = '{
    '{0,    0,    0, 64,  1,  0,  0},
    '{30,   20,   0, 64,  1,  2, -2},
    '{29,   20,   0, 64,  1,  1, -2},
    '{16,   0,    0, 14,  1,  1,  0},
    '{-16,  0,    0, 14,  1,  0, -2},
    '{-17,  0,    0, 14,  1, -1,  0},
    '{-51,  0,    0, 20,  1, -2, -1},
    '{60,   0,    0, 40,  0,  1,  2},
    '{-100, 0,    0, 90,  0, -1, -1},
    '{87,   0,    7, 40,  1,  1,  2},
    '{-30,  6,    4, 50,  1,  0, -2},
    '{511,  511,  3, 511, 1,  2,  0},
    '{-512, -512, 3, 511, 1, -2,  0},
    '{5,    0,    2, 0,   1,  0,  1}
  };

  function automatic void row(input int idx, output int h2, output int h1,
                              output int l2, output int l1);
    int t [8][4] = '{'{50,16,13,4}, '{56,16,14,4}, '{66,20,16,5}, '{68,20,17,5},
                     '{72,24,18,6}, '{80,24,20,6}, '{88,28,22,7}, '{88,28,22,7}};
    h2 = t[idx][0]; h1 = t[idx][1]; l2 = t[idx][2]; l1 = t[idx][3];
  endfunction

  function automatic int dec(input logic [2:0] v);
    return v[2] ? -int'(v[1:0]) : int'(v[1:0]);
  endfunction

  task automatic apply_check(input int ys, input int yc, input int idx, input int kd,
                             input bit r16, input int eh, input int el, input string tag);
    @(posedge clk);
    est_sum = 10'(ys); est_carry = 10'(yc); div_idx = 3'(idx);
    kd_est = 9'(kd); radix16 = r16;
    @(negedge clk);
    n_chk++;
    if (dec(q_hi) != eh || dec(q_lo) != el || q_hi == 3'b100 || q_lo == 3'b100) begin
      n_fail++;
      $display("FAIL %s: ys=%0d yc=%0d idx=%0d kd=%0d r16=%0d got hi=%0d lo=%0d (%b %b) exp hi=%0d lo=%0d",
               tag, ys, yc, idx, kd, r16, dec(q_hi), dec(q_lo), q_hi, q_lo, eh, el);
    end
  endtask

  function automatic void model(input int y, input int idx, input int kd, input bit r16,
                                output int eh, output int el);
    int h2, h1, l2, l1, v;
    row(idx, h2, h1, l2, l1);
    if (r16) eh = int'(y >= h2) + int'(y >= h1) + int'(y >= -h1) + int'(y >= -h2) - 2;
    else     eh = int'(y >= h1) + int'(y >= -h1) - 1;
    v  = y - eh * kd;
    el = int'(v >= l2) + int'(v >= l1) + int'(v >= -l1) + int'(v >= -l2) - 2;
  endfunction

  initial begin
    est_sum = '0; est_carry = '0; div_idx = '0; kd_est = '0; radix16 = 1'b1;
    repeat (2) @(posedge clk);
    // idle estimate yields zero digits (R5 encoding)
    apply_check(0, 0, 5, 0, 1, 0, 0, "R5 idle");
    // vector table: R2 R3 R4 R6 R7 R1 row selection
    for (int i = 0; i < NV; i++)
      apply_check(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4] != 0,
                  VEC[i][5], VEC[i][6], "R2/R3/R4/R6/R7 vector");
    // R1 every interval, R6 equality at hi1 and -hi2 for each row
    for (int idx = 0; idx < 8; idx++) begin
      int h2, h1, l2, l1, eh, el;
      row(idx, h2, h1, l2, l1);
      model(h1, idx, 3, 1'b1, eh, el);
      apply_check(h1, 0, idx, 3, 1'b1, eh, el, "R1 R6 at hi1");
      model(-h2, idx, 9, 1'b1, eh, el);
      apply_check(-h2, 0, idx, 9, 1'b1, eh, el, "R1 R6 at -hi2");
      model(-h1, idx, 5, 1'b0, eh, el);
      apply_check(-h1, 0, idx, 5, 1'b0, eh, el, "R3 R6 at -hi1");
    end
    // random sweep against the threshold model, both radices, all intervals
    for (int n = 0; n < 3000; n++) begin
      int ys, yc, idx, kd, eh, el;
      bit r16;
      ys  = int'($urandom_range(0, 1023)) - 512;
      yc  = int'($urandom_range(0, 1023)) - 512;
      if (n % 3 == 0) yc = int'($urandom_range(0, 200)) - 100;
      idx = n % 8;
      kd  = (n % 2 == 0) ? int'($urandom_range(0, 511)) : int'($urandom_range(0, 120));
      r16 = (n % 5) != 0;
      model(ys + yc, idx, kd, r16, eh, el);
      apply_check(ys, yc, idx, kd, r16, eh, el, r16 ? "R2 R4 random" : "R3 R4 random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8ns * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, got running exp done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule